// File: doc/BRIEF.md
# Transactional Cache Conflict Tracker

This block is a direct-mapped private cache for one core of a bus-based multicore. It supports lazy, optimistic hardware transactions. Each line holds a tag, one data word, and the flags valid, dirty and exclusive. Each line also has two tracking flags: "read in transaction" and "written in transaction". Speculative stores stay in the cache until commit. A line written in the open transaction is never written back and never supplied to another cache.

The core issues load, store, begin and commit operations. It holds a request, with address and data stable, until it sees either `core_ack` or `abort_pulse`. The block uses the bus port to issue shared reads, exclusive requests and write-backs, and it waits for one `bus_gnt` per request. The snoop port carries the requests of other cores. The block checks each snoop against the tracking flags and can supply dirty committed data.

Commit first walks the line indices in ascending order and gains exclusive ownership of every written line that lacks it. It then clears all tracking flags in a single cycle. Abort drops every written line and clears all flags in a single cycle. A conflict causes an abort, and so does a transaction that must evict a tracked line.

Top module: `txc_tracker`

## Requirements
- R1: A load inside a transaction that misses issues a shared request (bus_kind 0) for the load address and returns the filled data. The line is then marked as read, so a later exclusive snoop to it aborts the transaction.
- R2: A store inside a transaction that misses fetches the line with a shared request (bus_kind 0), never an exclusive one.
- R3: A shared snoop that hits a line written in the open transaction aborts it: `abort_pulse` is raised with `abort_cause` 1 (conflict). A shared snoop that hits a line that was only read does not abort.
- R4: An exclusive snoop that hits a line marked as read or as written aborts the transaction with cause 1.
- R5: After an abort, lines written in the transaction are invalid, so the next access refetches them from the bus. Lines that were only read stay valid and hit without any bus request.
- R6: Commit issues an exclusive request (bus_kind 1) for each written line without ownership, in ascending index order. It then acknowledges with `commit_done` high for one cycle, and `tx_active` is low.
- R7: After commit, the written lines are dirty, valid data. A shared snoop on such a line raises `snp_supply` with the committed word and does not abort. Snoops to lines that were only read no longer abort.
- R8: A line written in the open transaction is never supplied on a snoop (`snp_supply` low) and is never written back (bus_kind 2). Its speculative value never reaches memory.
- R9: A transactional miss whose victim line is marked as read or as written aborts with `abort_cause` 2 (overflow) and issues no bus request.
- R10: After reset, `tx_active`, `abort_pulse` and `bus_req` are low. `abort_pulse` lasts exactly one cycle, and `tx_active` is low from that cycle on.
- R11: While the commit walk runs, snoops that would otherwise conflict cause no abort, and the commit completes.
- R12: Outside a transaction, a store needs ownership: a miss issues an exclusive request (bus_kind 1). Evicting a dirty line first writes it back (bus_kind 2, with its data), then issues the fill.
- R13: A store inside a transaction to a line that holds dirty committed data first writes that data back (bus_kind 2). It then writes the speculative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Core request, held until ack or abort |
| core_op | input | 2 | 0 load, 1 store, 2 begin, 3 commit |
| core_addr | input | ADDR_W | Word address of the access |
| core_wdata | input | DATA_W | Store data |
| core_ack | output | 1 | One-cycle completion of the held request |
| core_rdata | output | DATA_W | Load result, valid with core_ack |
| tx_active | output | 1 | A transaction is open |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_cause | output | 2 | 1 conflict, 2 overflow (valid with abort_pulse) |
| commit_done | output | 1 | One-cycle end of a successful commit |
| bus_req | output | 1 | Bus request pending |
| bus_kind | output | 2 | 0 shared read, 1 exclusive, 2 write-back |
| bus_addr | output | ADDR_W | Request address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Request granted, fill data valid |
| bus_rdata | input | DATA_W | Fill data |
| snp_valid | input | 1 | Snooped request present this cycle |
| snp_excl | input | 1 | Snooped request is exclusive |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supply | output | 1 | This cache supplies dirty data for the snoop |
| snp_data | output | DATA_W | Supplied data |

## Verification
The bench targets the asymmetric snoop rule. It sends a shared snoop to a line that was only read, which must not abort, and one to a written line, which must abort. A design that treats both flags alike either aborts needlessly or lets speculative data leak. The bench evicts a written line to show that nothing is written back and that the later fill brings the old memory value. It stores speculatively over a dirty committed line; a design that skipped the write-back would lose the committed value on abort. Finally it snoops in the middle of the commit walk and checks the order of the upgrade requests. A design that aborted there, or walked out of order, shows up as a missing commit_done or as a bus event out of order in the scoreboard.

// File: rtl/txc_pkg.sv
// Shared types for the transactional cache tracker.
package txc_pkg;
    typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_BEGIN = 2'd2, OP_COMMIT = 2'd3} core_op_e;
    typedef enum logic [1:0] {BK_SHARED = 2'd0, BK_EXCL = 2'd1, BK_WB = 2'd2} bus_kind_e;
    typedef enum logic [1:0] {CAUSE_NONE = 2'd0, CAUSE_CONFLICT = 2'd1, CAUSE_OVERFLOW = 2'd2} abort_cause_e;
    typedef enum logic [1:0] {ST_READY = 2'd0, ST_WB = 2'd1, ST_FILL = 2'd2, ST_COMMIT = 2'd3} ctl_state_e;
endpackage

// File: rtl/txc_lookup.sv
// Tag comparator for one line.
// Assumes the caller has already selected the line by index.
module txc_lookup #(
    parameter int TAG_W = 13
) (
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit
);
    // Hit when the line is valid and its stored tag matches the request tag.
    always_comb hit = line_valid && (line_tag == req_tag);
endmodule

// File: rtl/txc_snoop_eval.sv
// Evaluates one snooped request against the addressed line.
// Produces: conflict, data supply, invalidate and downgrade decisions.
// Assumes check_en is high only while a transaction runs outside its commit walk,
// and commit_phase is high during the walk.
module txc_snoop_eval (
    input  logic snp_valid,
    input  logic snp_excl,
    input  logic hit,
    input  logic line_rd,
    input  logic line_wr,
    input  logic line_dirty,
    input  logic check_en,
    input  logic commit_phase,
    output logic conflict,
    output logic supply,
    output logic drop,
    output logic downgrade
);
    logic seen;
    logic guarded;

    // Decide the effect of the snoop on this line.
    always_comb begin
        seen      = snp_valid && hit;
        guarded   = commit_phase && (line_rd || line_wr);
        conflict  = seen && check_en && (line_wr || (snp_excl && line_rd));
        supply    = seen && line_dirty && !line_wr;
        drop      = seen && snp_excl && !guarded;
        downgrade = seen && !snp_excl && !line_wr;
    end
endmodule

// File: rtl/txc_tracker.sv
// Direct-mapped private cache with per-line read and write tracking
// for lazy, optimistic transactions.
// Assumptions:
//   - the core holds core_req, core_op, core_addr and core_wdata stable until
//     core_ack or abort_pulse;
//   - the bus answers every request with exactly one bus_gnt;
//   - during a commit walk this core holds commit priority on the bus.
module txc_tracker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic [1:0]        core_op,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_ack,
    output logic [DATA_W-1:0] core_rdata,
    output logic              tx_active,
    output logic              abort_pulse,
    output logic [1:0]        abort_cause,
    output logic              commit_done,
    output logic              bus_req,
    output logic [1:0]        bus_kind,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_excl,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);
    import txc_pkg::*;

    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    logic [LINES-1:0]  valid_q, dirty_q, excl_q, rd_q, wr_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    ctl_state_e       state_q;
    logic             tx_q;
    logic             fill_excl_q;
    logic [IDX_W-1:0] walk_q;

    logic [IDX_W-1:0] c_idx, s_idx;
    logic [TAG_W-1:0] c_tag, s_tag;
    logic             c_hit, s_hit;
    logic             s_conflict, s_drop, s_down;
    logic [LINES-1:0] kill_mask, down_mask, tracked;
    logic             walk_need, victim_busy;
    core_op_e         op;

    // Split the core and snoop addresses into index and tag.
    always_comb begin
        c_idx = core_addr[IDX_W-1:0];
        c_tag = core_addr[ADDR_W-1:IDX_W];
        s_idx = snp_addr[IDX_W-1:0];
        s_tag = snp_addr[ADDR_W-1:IDX_W];
        op    = core_op_e'(core_op);
    end

    txc_lookup #(.TAG_W(TAG_W)) u_core_lookup (
        .line_valid (valid_q[c_idx]),
        .line_tag   (tag_q[c_idx]),
        .req_tag    (c_tag),
        .hit        (c_hit)
    );

    txc_lookup #(.TAG_W(TAG_W)) u_snoop_lookup (
        .line_valid (valid_q[s_idx]),
        .line_tag   (tag_q[s_idx]),
        .req_tag    (s_tag),
        .hit        (s_hit)
    );

    txc_snoop_eval u_snoop_eval (
        .snp_valid    (snp_valid),
        .snp_excl     (snp_excl),
        .hit          (s_hit),
        .line_rd      (rd_q[s_idx]),
        .line_wr      (wr_q[s_idx]),
        .line_dirty   (dirty_q[s_idx]),
        .check_en     (tx_q && (state_q != ST_COMMIT)),
        .commit_phase (state_q == ST_COMMIT),
        .conflict     (s_conflict),
        .supply       (snp_supply),
        .drop         (s_drop),
        .downgrade    (s_down)
    );

    // Per-line masks for the snoop effects and for victim and walk checks.
    always_comb begin
        kill_mask   = '0;
        down_mask   = '0;
        kill_mask[s_idx] = s_drop;
        down_mask[s_idx] = s_down;
        tracked     = rd_q | wr_q;
        victim_busy = valid_q[c_idx] && tracked[c_idx];
        walk_need   = valid_q[walk_q] && wr_q[walk_q] && !excl_q[walk_q];
        snp_data    = data_q[s_idx];
        tx_active   = tx_q;
    end

    // Drive the bus request from the controller state.
    always_comb begin
        bus_req   = 1'b0;
        bus_kind  = BK_SHARED;
        bus_addr  = core_addr;
        bus_wdata = data_q[c_idx];
        case (state_q)
            ST_WB: begin
                bus_req  = 1'b1;
                bus_kind = BK_WB;
                bus_addr = {tag_q[c_idx], c_idx};
            end
            ST_FILL: begin
                bus_req  = 1'b1;
                bus_kind = fill_excl_q ? BK_EXCL : BK_SHARED;
            end
            ST_COMMIT: begin
                bus_req  = walk_need;
                bus_kind = BK_EXCL;
                bus_addr = {tag_q[walk_q], walk_q};
            end
            default: ;
        endcase
    end

    // Controller: core operations, fills, write-backs, commit walk, aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_READY;
            tx_q        <= 1'b0;
            fill_excl_q <= 1'b0;
            walk_q      <= '0;
            valid_q     <= '0;
            dirty_q     <= '0;
            excl_q      <= '0;
            rd_q        <= '0;
            wr_q        <= '0;
            core_ack    <= 1'b0;
            core_rdata  <= '0;
            abort_pulse <= 1'b0;
            abort_cause <= CAUSE_NONE;
            commit_done <= 1'b0;
        end else begin
            core_ack    <= 1'b0;
            abort_pulse <= 1'b0;
            commit_done <= 1'b0;
            if (s_drop) valid_q[s_idx] <= 1'b0;
            if (s_down) begin
                excl_q[s_idx]  <= 1'b0;
                dirty_q[s_idx] <= 1'b0;
            end
            if (s_conflict) begin
                valid_q     <= valid_q & ~wr_q & ~kill_mask;
                rd_q        <= '0;
                wr_q        <= '0;
                tx_q        <= 1'b0;
                abort_pulse <= 1'b1;
                abort_cause <= CAUSE_CONFLICT;
                state_q     <= ST_READY;
            end else begin
                case (state_q)
                    ST_READY: begin
                        if (core_req && !core_ack && !abort_pulse) begin
                            case (op)
                                OP_BEGIN: begin
                                    tx_q     <= 1'b1;
                                    core_ack <= 1'b1;
                                end
                                OP_COMMIT: begin
                                    if (tx_q) begin
                                        state_q <= ST_COMMIT;
                                        walk_q  <= '0;
                                    end else begin
                                        core_ack <= 1'b1;
                                    end
                                end
                                default: begin
                                    if (c_hit && op == OP_LOAD) begin
                                        core_ack   <= 1'b1;
                                        core_rdata <= data_q[c_idx];
                                        if (tx_q) rd_q[c_idx] <= 1'b1;
                                    end else if (c_hit && tx_q && (wr_q[c_idx] || !dirty_q[c_idx])) begin
                                        data_q[c_idx] <= core_wdata;
                                        wr_q[c_idx]   <= 1'b1;
                                        core_ack      <= 1'b1;
                                    end else if (c_hit && tx_q) begin
                                        state_q <= ST_WB;
                                    end else if (c_hit && excl_q[c_idx]) begin
                                        data_q[c_idx]  <= core_wdata;
                                        dirty_q[c_idx] <= 1'b1;
                                        core_ack       <= 1'b1;
                                    end else if (c_hit) begin
                                        state_q     <= ST_FILL;
                                        fill_excl_q <= 1'b1;
                                    end else if (tx_q && victim_busy) begin
                                        valid_q     <= valid_q & ~wr_q & ~kill_mask;
                                        rd_q        <= '0;
                                        wr_q        <= '0;
                                        tx_q        <= 1'b0;
                                        abort_pulse <= 1'b1;
                                        abort_cause <= CAUSE_OVERFLOW;
                                    end else if (valid_q[c_idx] && dirty_q[c_idx]) begin
                                        state_q <= ST_WB;
                                    end else begin
                                        state_q     <= ST_FILL;
                                        fill_excl_q <= !tx_q && (op == OP_STORE);
                                    end
                                end
                            endcase
                        end
                    end
                    ST_WB: begin
                        if (bus_gnt) begin
                            dirty_q[c_idx] <= 1'b0;
                            state_q        <= ST_READY;
                        end
                    end
                    ST_FILL: begin
                        if (bus_gnt) begin
                            valid_q[c_idx] <= 1'b1;
                            tag_q[c_idx]   <= c_tag;
                            data_q[c_idx]  <= bus_rdata;
                            excl_q[c_idx]  <= fill_excl_q;
                            dirty_q[c_idx] <= 1'b0;
                            rd_q[c_idx]    <= 1'b0;
                            wr_q[c_idx]    <= 1'b0;
                            state_q        <= ST_READY;
                        end
                    end
                    ST_COMMIT: begin
                        if (!walk_need || bus_gnt) begin
                            if (walk_need) excl_q[walk_q] <= 1'b1;
                            if (walk_q == LAST_IDX) begin
                                dirty_q     <= (dirty_q & ~down_mask) | wr_q;
                                rd_q        <= '0;
                                wr_q        <= '0;
                                tx_q        <= 1'b0;
                                core_ack    <= 1'b1;
                                commit_done <= 1'b1;
                                state_q     <= ST_READY;
                            end else begin
                                walk_q <= walk_q + 1'b1;
                            end
                        end
                    end
                    default: state_q <= ST_READY;
                endcase
            end
        end
    end

    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse); // R10
    AST_ABORT_ENDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> !tx_active); // R10
    AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (abort_cause != CAUSE_NONE)); // R9
    AST_NO_SPEC_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_kind == BK_WB) |-> !wr_q[bus_addr[IDX_W-1:0]]); // R8
    AST_TX_FILL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && tx_q) |-> (bus_kind == BK_SHARED)); // R2
    AST_COMMIT_CLEARS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> (!tx_active && rd_q == '0 && wr_q == '0)); // R6
    AST_WALK_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && $past(state_q == ST_COMMIT)) |-> (walk_q >= $past(walk_q))); // R6
    AST_NO_ABORT_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> !(abort_pulse && abort_cause == CAUSE_CONFLICT)); // R11
endmodule

// File: tb/tb_txc_tracker.sv
module tb_txc_tracker;
    localparam int AW = 16;
    localparam int DW = 32;

    typedef struct {
        logic [1:0]    kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        string         tag;
    } bus_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_req = 1'b0;
    logic [1:0] core_op = 2'd0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic core_ack, tx_active, abort_pulse, commit_done;
    logic [DW-1:0] core_rdata;
    logic [1:0] abort_cause;
    logic bus_req;
    logic [1:0] bus_kind;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic bus_gnt = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic snp_valid = 1'b0;
    logic snp_excl = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic snp_supply;
    logic [DW-1:0] snp_data;

    int total = 0;
    int fails = 0;
    bit finished = 0;
    bus_item_t expq[$];
    logic [DW-1:0] mem [int];
    logic [1:0] last_cause;
    logic last_done;

    always #4 clk = ~clk;

    txc_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_op(core_op), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_ack(core_ack), .core_rdata(core_rdata), .tx_active(tx_active),
        .abort_pulse(abort_pulse), .abort_cause(abort_cause), .commit_done(commit_done),
        .bus_req(bus_req), .bus_kind(bus_kind), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
        .snp_supply(snp_supply), .snp_data(snp_data)
    );

    function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return {16'hD000, a};
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_bus(input logic [1:0] k, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input string tag);
        bus_item_t it;
        it.kind = k; it.addr = a; it.wdata = d; it.tag = tag;
        expq.push_back(it);
    endtask

    // Bus responder and scoreboard monitor: grants each request and compares it.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_gnt) begin
                bus_gnt = 1'b0;
            end else if (bus_req) begin
                if (expq.size() == 0) begin
                    total++; fails++;
                    $display("FAIL unexpected bus event: actual kind %0d addr %h expected none",
                             bus_kind, bus_addr);
                end else begin
                    bus_item_t it;
                    it = expq.pop_front();
                    chk({it.tag, " bus kind"}, {30'd0, bus_kind}, {30'd0, it.kind});
                    chk({it.tag, " bus addr"}, {16'd0, bus_addr}, {16'd0, it.addr});
                    if (it.kind == 2'd2) chk({it.tag, " wb data"}, bus_wdata, it.wdata);
                end
                if (bus_kind == 2'd2) mem[int'(bus_addr)] = bus_wdata;
                else bus_rdata = mem_rd(bus_addr);
                bus_gnt = 1'b1;
            end
        end
    end

    task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] rd, output logic ab);
        core_op = op; core_addr = a; core_wdata = d; core_req = 1'b1;
        do @(negedge clk); while (!core_ack && !abort_pulse);
        rd = core_rdata;
        ab = abort_pulse;
        last_cause = abort_cause;
        last_done = commit_done;
        core_req = 1'b0;
    endtask

    task automatic snoop(input logic ex, input logic [AW-1:0] a,
                         output logic sup, output logic [DW-1:0] sd, output logic ab);
        snp_valid = 1'b1; snp_excl = ex; snp_addr = a;
        #1;
        sup = snp_supply;
        sd = snp_data;
        @(negedge clk);
        snp_valid = 1'b0;
        ab = abort_pulse;
        last_cause = abort_cause;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // Stimulus and result checks.
    initial begin
        logic [DW-1:0] rd, sd;
        logic ab, sup, ab2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset tx_active", {31'd0, tx_active}, 32'd0);
        chk("R10 reset abort", {31'd0, abort_pulse}, 32'd0);
        chk("R10 reset bus_req", {31'd0, bus_req}, 32'd0);

        // R12: stores outside a transaction need ownership; dirty eviction writes back
        expect_bus(2'd1, 16'h0010, '0, "R12");
        do_op(2'd1, 16'h0010, 32'h11, rd, ab);
        chk("R12 store ack", {31'd0, ab}, 32'd0);
        do_op(2'd0, 16'h0010, '0, rd, ab);
        chk("R12 load hit", rd, 32'h11);
        expect_bus(2'd2, 16'h0010, 32'h11, "R12");
        expect_bus(2'd0, 16'h0018, '0, "R12");
        do_op(2'd0, 16'h0018, '0, rd, ab);
        chk("R12 evict fill", rd, 32'hD0000018);

        // R1, R2, R3, R8, R10: transactional fills, shared snoop rules
        do_op(2'd2, '0, '0, rd, ab);
        expect_bus(2'd0, 16'h0021, '0, "R1");
        do_op(2'd0, 16'h0021, '0, rd, ab);
        chk("R1 tx load data", rd, 32'hD0000021);
        expect_bus(2'd0, 16'h0022, '0, "R2");
        do_op(2'd1, 16'h0022, 32'h2222, rd, ab);
        snoop(1'b0, 16'h0021, sup, sd, ab);
        chk("R3 shared snoop on read line", {31'd0, ab}, 32'd0);
        snoop(1'b0, 16'h0022, sup, sd, ab);
        chk("R8 no supply of spec line", {31'd0, sup}, 32'd0);
        chk("R3 shared snoop on written line aborts", {31'd0, ab}, 32'd1);
        chk("R3 cause conflict", {30'd0, last_cause}, 32'd1);
        chk("R10 tx ends on abort", {31'd0, tx_active}, 32'd0);
        @(negedge clk);
        chk("R10 abort one cycle", {31'd0, abort_pulse}, 32'd0);

        // R5: written lines dropped, read lines kept
        expect_bus(2'd0, 16'h0022, '0, "R5");
        do_op(2'd0, 16'h0022, '0, rd, ab);
        chk("R5 written line refetched", rd, 32'hD0000022);
        do_op(2'd0, 16'h0021, '0, rd, ab);
        chk("R5 read line kept", rd, 32'hD0000021);

        // R4: exclusive snoop on read line and on written line
        do_op(2'd2, '0, '0, rd, ab);
        do_op(2'd0, 16'h0021, '0, rd, ab);
        snoop(1'b1, 16'h0021, sup, sd, ab);
        chk("R4 excl snoop on read line", {31'd0, ab}, 32'd1);
        chk("R4 cause", {30'd0, last_cause}, 32'd1);
        do_op(2'd2, '0, '0, rd, ab);
        expect_bus(2'd0, 16'h0021, '0, "R4");
        do_op(2'd1, 16'h0021, 32'h99, rd, ab);
        snoop(1'b1, 16'h0021, sup, sd, ab);
        chk("R4 excl snoop on written line", {31'd0, ab}, 32'd1);

        // R6, R7: commit walk and committed state
        do_op(2'd2, '0, '0, rd, ab);
        expect_bus(2'd0, 16'h0033, '0, "R2");
        do_op(2'd1, 16'h0033, 32'h3333, rd, ab);
        expect_bus(2'd0, 16'h0035, '0, "R2");
        do_op(2'd1, 16'h0035, 32'h3535, rd, ab);
        expect_bus(2'd0, 16'h0021, '0, "R1");
        do_op(2'd0, 16'h0021, '0, rd, ab);
        do_op(2'd1, 16'h0018, 32'h4444, rd, ab);
        expect_bus(2'd1, 16'h0018, '0, "R6");
        expect_bus(2'd1, 16'h0033, '0, "R6");
        expect_bus(2'd1, 16'h0035, '0, "R6");
        do_op(2'd3, '0, '0, rd, ab);
        chk("R6 commit no abort", {31'd0, ab}, 32'd0);
        chk("R6 commit_done", {31'd0, last_done}, 32'd1);
        chk("R6 tx closed", {31'd0, tx_active}, 32'd0);
        snoop(1'b0, 16'h0033, sup, sd, ab);
        chk("R7 supply committed", {31'd0, sup}, 32'd1);
        chk("R7 supplied data", sd, 32'h3333);
        chk("R7 no abort", {31'd0, ab}, 32'd0);
        snoop(1'b1, 16'h0021, sup, sd, ab);
        chk("R7 read set cleared", {31'd0, ab}, 32'd0);

        // R11: snoop during the commit walk is ignored
        do_op(2'd2, '0, '0, rd, ab);
        expect_bus(2'd0, 16'h0024, '0, "R1");
        do_op(2'd0, 16'h0024, '0, rd, ab);
        expect_bus(2'd0, 16'h0026, '0, "R2");
        do_op(2'd1, 16'h0026, 32'h2626, rd, ab);
        expect_bus(2'd1, 16'h0026, '0, "R11");
        fork
            do_op(2'd3, '0, '0, rd, ab);
            begin
                @(negedge clk);
                @(negedge clk);
                snoop(1'b1, 16'h0024, sup, sd, ab2);
            end
        join
        chk("R11 commit not aborted", {31'd0, ab}, 32'd0);
        chk("R11 commit_done", {31'd0, last_done}, 32'd1);
        chk("R11 snoop no abort", {31'd0, ab2}, 32'd0);

        // R9, R8: overflow abort, speculative value never reaches memory
        do_op(2'd2, '0, '0, rd, ab);
        expect_bus(2'd0, 16'h0027, '0, "R2");
        do_op(2'd1, 16'h0027, 32'h2727, rd, ab);
        do_op(2'd0, 16'h002F, '0, rd, ab);
        chk("R9 overflow abort", {31'd0, ab}, 32'd1);
        chk("R9 overflow cause", {30'd0, last_cause}, 32'd2);
        chk("R9 tx closed", {31'd0, tx_active}, 32'd0);
        expect_bus(2'd0, 16'h0027, '0, "R8");
        do_op(2'd0, 16'h0027, '0, rd, ab);
        chk("R8 memory holds old value", rd, 32'hD0000027);

        // R13: speculative store over dirty committed data writes it back first
        do_op(2'd2, '0, '0, rd, ab);
        expect_bus(2'd2, 16'h0018, 32'h4444, "R13");
        do_op(2'd1, 16'h0018, 32'h7777, rd, ab);
        chk("R13 store acked", {31'd0, ab}, 32'd0);
        snoop(1'b1, 16'h0018, sup, sd, ab);
        chk("R13 abort after snoop", {31'd0, ab}, 32'd1);
        expect_bus(2'd0, 16'h0018, '0, "R13");
        do_op(2'd0, 16'h0018, '0, rd, ab);
        chk("R13 committed value kept", rd, 32'h4444);

        repeat (3) @(negedge clk);
        chk("R12 all bus events seen", expq.size(), 32'd0);
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule